// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

This block runs one DMA channel. Software loads a source address, a destination address and a unit count. The channel then copies data one unit at a time over a simple request/acknowledge memory port. Each unit is a read from the source, with the returned word held in a register, followed by a write of that word to the destination. After each unit both addresses advance by the unit size and the count drops by one.

Work starts only when every enable term is satisfied, and only when the selected request source calls for a unit. A run ends in one of two ways. In a normal end the count reaches zero, the end flag is set and, if enabled, the completion interrupt is raised. In an abort an NMI event or a cleared enable stops the channel after the unit already in flight. An abort raises no interrupt and leaves the remaining count in place. In burst mode the channel keeps the bus from one unit to the next. In cycle-steal mode it hands the bus back after every unit.

Top module: `dma_chan_seq`

## Requirements
- R1: No memory request is issued unless all of the following hold: `ch_en`=1, `mst_en`=1, `end_flag`=0, `addr_err`=0 and `nmi_flag`=0. Once a run has ended normally, the channel does not start again until the next `cfg_load`.
- R2: `req_src` selects what starts a unit:
  - 00 (auto) starts as soon as the unit is qualified.
  - 01 (external) starts while `ext_req` is high.
  - 10 (peripheral) starts one unit for each one-cycle `per_req` strobe. The strobe is held pending until that unit starts.
  - 11 starts nothing.
- R3: Each unit reads `cur_src` (`mem_we`=0) and then writes `cur_dst` (`mem_we`=1). The write data equals the read data unchanged, and `mem_size` equals `xfer_size` on both accesses.
- R4: `xfer_size` 00 means byte, 01 means 16-bit and 10 means 32-bit. After each unit both addresses advance by 1, 2 or 4 respectively. Code 11 is reserved and starts no unit.
- R5: `cur_cnt` decrements by one after each completed write. A loaded count of zero starts no unit.
- R6: When the last unit's write completes, `end_flag` is set. `done_irq` is set at the same time only if `irq_en`=1. `cfg_load` clears both flags.
- R7: A one-cycle `nmi_evt` pulse sets the sticky `nmi_flag`. The unit already in flight still completes its write, and the channel then stops. The remaining count is kept, `end_flag` stays 0 and `done_irq` stays 0.
- R8: If `ch_en` or `mst_en` is cleared during a unit, that unit completes and the channel stops with the remaining count kept. Setting the enable again resumes the run from the kept addresses and count.
- R9: With `burst_mode`=1, `bus_hold` stays high from the first unit to the last. With `burst_mode`=0, `bus_hold` goes low for at least one cycle between units.
- R10: While reset is held and just after it is released: `mem_req`, `bus_hold`, `end_flag`, `nmi_flag` and `done_irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Load addresses and count; clear the end, NMI and interrupt flags |
| cfg_src | input | AW | Source start address |
| cfg_dst | input | AW | Destination start address |
| cfg_cnt | input | CW | Number of units |
| ch_en | input | 1 | Channel enable |
| mst_en | input | 1 | Master enable |
| irq_en | input | 1 | Completion interrupt enable |
| burst_mode | input | 1 | 1 = burst, 0 = cycle steal |
| xfer_size | input | 2 | Unit size code |
| req_src | input | 2 | Request source select |
| ext_req | input | 1 | External request level |
| per_req | input | 1 | Peripheral request strobe |
| nmi_evt | input | 1 | NMI event pulse |
| addr_err | input | 1 | Address-error flag |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Access address |
| mem_size | output | 2 | Access size code |
| mem_wdata | output | DW | Write data |
| mem_ack | input | 1 | Access complete |
| mem_rdata | input | DW | Read data, valid with `mem_ack` |
| bus_hold | output | 1 | Channel owns the bus |
| end_flag | output | 1 | Normal end reached |
| nmi_flag | output | 1 | NMI abort flag |
| done_irq | output | 1 | Completion interrupt |
| cur_src | output | AW | Current source address |
| cur_dst | output | AW | Current destination address |
| cur_cnt | output | CW | Remaining units |

## Verification
A wrong count or a wrong address step shows up at the memory port within one unit, about four cycles. It appears as a write to the wrong address, a write carrying data from the wrong source word, or one unit too many or too few before `end_flag` rises. A sequencer stuck in the wrong state shows either as a write with no preceding read or as a burst that drops `bus_hold`. An abort path that is wrong shows as extra writes, or as a lost remaining count, within a few cycles of `nmi_evt` or of an enable falling.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2
  } xfer_st_e;

  typedef enum logic [1:0] {
    SRC_AUTO   = 2'd0,
    SRC_EXT    = 2'd1,
    SRC_PERIPH = 2'd2,
    SRC_NONE   = 2'd3
  } req_src_e;

  // Bytes moved per unit; zero marks the reserved code.
  function automatic logic [2:0] unit_bytes(input logic [1:0] sz);
    case (sz)
      2'b00:   unit_bytes = 3'd1;
      2'b01:   unit_bytes = 3'd2;
      2'b10:   unit_bytes = 3'd4;
      default: unit_bytes = 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/dma_req_sel.sv
module dma_req_sel
  import dma_chan_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] req_src,
  input  logic       ext_req,
  input  logic       per_req,
  input  logic       take,
  output logic       req_any
);

  logic pend_q, pend_d, pend_en;

  always_comb begin
    pend_d = pend_q;
    if (take) pend_d = 1'b0;
    if (per_req && req_src == SRC_PERIPH) pend_d = 1'b1;
  end

  assign pend_en = take | per_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= 1'b0;
    else if (pend_en) pend_q <= pend_d;
  end

  always_comb begin
    case (req_src)
      SRC_AUTO:   req_any = 1'b1;
      SRC_EXT:    req_any = ext_req;
      SRC_PERIPH: req_any = pend_q;
      default:    req_any = 1'b0;
    endcase
  end

  // R2: a strobe is consumed when the unit it asked for starts
  a_r2_pend_consumed: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !per_req) |=> !pend_q);

endmodule

// File: rtl/dma_addr_cnt.sv
module dma_addr_cnt #(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] src_in,
  input  logic [AW-1:0] dst_in,
  input  logic [CW-1:0] cnt_in,
  input  logic          step,
  input  logic [2:0]    step_bytes,
  output logic [AW-1:0] src_q,
  output logic [AW-1:0] dst_q,
  output logic [CW-1:0] cnt_q,
  output logic          cnt_last,
  output logic          cnt_zero
);

  logic [AW-1:0] src_d, dst_d;
  logic [CW-1:0] cnt_d;
  logic          upd_en;

  always_comb begin
    src_d = src_q;
    dst_d = dst_q;
    cnt_d = cnt_q;
    if (load) begin
      src_d = src_in;
      dst_d = dst_in;
      cnt_d = cnt_in;
    end else if (step) begin
      src_d = src_q + AW'(step_bytes);
      dst_d = dst_q + AW'(step_bytes);
      cnt_d = cnt_q - 1'b1;
    end
  end

  assign upd_en = load | step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;
      dst_q <= '0;
      cnt_q <= '0;
    end else if (upd_en) begin
      src_q <= src_d;
      dst_q <= dst_d;
      cnt_q <= cnt_d;
    end
  end

  assign cnt_last = (cnt_q == CW'(1));
  assign cnt_zero = (cnt_q == '0);

  // R5: one unit, one decrement
  a_r5_count_dec: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> cnt_q == $past(cnt_q) - 1'b1);

  // R4: source moves by the unit size
  a_r4_src_adv: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> src_q == $past(src_q) + AW'($past(step_bytes)));

endmodule

// File: rtl/dma_xfer_fsm.sv
module dma_xfer_fsm
  import dma_chan_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          qual_ok,
  input  logic          req_any,
  input  logic          burst,
  input  logic          cnt_last,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata,
  output xfer_st_e      st_q,
  output logic [DW-1:0] wdata,
  output logic          take,
  output logic          step,
  output logic          done_ok
);

  xfer_st_e      st_d;
  logic [DW-1:0] data_q;
  logic          data_en;

  always_comb begin
    st_d    = st_q;
    take    = 1'b0;
    step    = 1'b0;
    done_ok = 1'b0;
    case (st_q)
      ST_IDLE: if (qual_ok && req_any) begin
        st_d = ST_RD;
        take = 1'b1;
      end
      ST_RD: if (mem_ack) st_d = ST_WR;
      ST_WR: if (mem_ack) begin
        step = 1'b1;
        if (cnt_last) begin
          done_ok = 1'b1;
          st_d    = ST_IDLE;
        end else if (qual_ok && burst) begin
          st_d = ST_RD;
        end else begin
          st_d = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign data_en = (st_q == ST_RD) && mem_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (data_en) data_q <= mem_rdata;
  end

  assign wdata = data_q;

  // R3: a write phase is only ever entered from a read phase
  a_r3_wr_after_rd: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WR && $past(st_q) != ST_WR) |-> $past(st_q) == ST_RD);

  // R3: latched data holds still while the write waits
  a_r3_wdata_held: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WR && $past(st_q) == ST_WR) |-> $stable(wdata));

  // R9: cycle steal gives the bus back after each unit
  a_r9_steal_release: assert property (@(posedge clk) disable iff (!rst_n)
    (!burst && st_q == ST_WR && mem_ack) |=> st_q == ST_IDLE);

endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
  import dma_chan_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_load,
  input  logic [AW-1:0] cfg_src,
  input  logic [AW-1:0] cfg_dst,
  input  logic [CW-1:0] cfg_cnt,
  input  logic          ch_en,
  input  logic          mst_en,
  input  logic          irq_en,
  input  logic          burst_mode,
  input  logic [1:0]    xfer_size,
  input  logic [1:0]    req_src,
  input  logic          ext_req,
  input  logic          per_req,
  input  logic          nmi_evt,
  input  logic          addr_err,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [1:0]    mem_size,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata,
  output logic          bus_hold,
  output logic          end_flag,
  output logic          nmi_flag,
  output logic          done_irq,
  output logic [AW-1:0] cur_src,
  output logic [AW-1:0] cur_dst,
  output logic [CW-1:0] cur_cnt
);

  xfer_st_e   st;
  logic       req_any, take, step, done_ok;
  logic       cnt_last, cnt_zero, qual_ok;
  logic [2:0] ubytes;
  logic       end_d, nmi_d, irq_d, flag_en;

  assign ubytes  = unit_bytes(xfer_size);
  assign qual_ok = ch_en && mst_en && !end_flag && !addr_err && !nmi_flag
                   && (ubytes != 3'd0) && !cnt_zero;

  dma_req_sel u_req (
    .clk(clk), .rst_n(rst_n), .req_src(req_src), .ext_req(ext_req),
    .per_req(per_req), .take(take), .req_any(req_any)
  );

  dma_addr_cnt #(.AW(AW), .CW(CW)) u_dp (
    .clk(clk), .rst_n(rst_n), .load(cfg_load), .src_in(cfg_src),
    .dst_in(cfg_dst), .cnt_in(cfg_cnt), .step(step), .step_bytes(ubytes),
    .src_q(cur_src), .dst_q(cur_dst), .cnt_q(cur_cnt),
    .cnt_last(cnt_last), .cnt_zero(cnt_zero)
  );

  dma_xfer_fsm #(.DW(DW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .qual_ok(qual_ok), .req_any(req_any),
    .burst(burst_mode), .cnt_last(cnt_last), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .st_q(st), .wdata(mem_wdata), .take(take),
    .step(step), .done_ok(done_ok)
  );

  always_comb begin
    end_d = end_flag;
    nmi_d = nmi_flag;
    irq_d = done_irq;
    if (cfg_load) begin
      end_d = 1'b0;
      nmi_d = 1'b0;
      irq_d = 1'b0;
    end
    if (done_ok) begin
      end_d = 1'b1;
      if (irq_en) irq_d = 1'b1;
    end
    if (nmi_evt) nmi_d = 1'b1;
  end

  assign flag_en = cfg_load | done_ok | nmi_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      end_flag <= 1'b0;
      nmi_flag <= 1'b0;
      done_irq <= 1'b0;
    end else if (flag_en) begin
      end_flag <= end_d;
      nmi_flag <= nmi_d;
      done_irq <= irq_d;
    end
  end

  assign mem_req  = (st == ST_RD) || (st == ST_WR);
  assign mem_we   = (st == ST_WR);
  assign mem_addr = (st == ST_WR) ? cur_dst : cur_src;
  assign mem_size = xfer_size;
  assign bus_hold = (st != ST_IDLE);

  // R1: every run start was qualified the cycle before
  a_r1_start_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_hold) |-> $past(qual_ok));

  // R6: the interrupt only accompanies a normal end
  a_r6_irq_needs_end: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |-> end_flag);

  // R7: the NMI flag is sticky until the next load
  a_r7_nmi_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_flag && !cfg_load) |=> nmi_flag);

endmodule

// File: tb/dma_chan_seq_bench.sv
module dma_chan_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int CW = 16;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_load = 1'b0;
  logic [AW-1:0] cfg_src = '0;
  logic [AW-1:0] cfg_dst = '0;
  logic [CW-1:0] cfg_cnt = '0;
  logic          ch_en = 1'b0, mst_en = 1'b0, irq_en = 1'b0, burst_mode = 1'b0;
  logic [1:0]    xfer_size = 2'b10, req_src = 2'b00;
  logic          ext_req = 1'b0, per_req = 1'b0, nmi_evt = 1'b0, addr_err = 1'b0;
  logic          mem_req, mem_we, mem_ack;
  logic [AW-1:0] mem_addr;
  logic [1:0]    mem_size;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic          bus_hold, end_flag, nmi_flag, done_irq;
  logic [AW-1:0] cur_src, cur_dst;
  logic [CW-1:0] cur_cnt;

  int total = 0;
  int bad = 0;
  int wr_seen = 0;
  int req_seen = 0;
  int gaps = 0;
  bit run_on = 1'b0;
  bit first_wr = 1'b0;

  logic [AW-1:0] q_addr[$];
  logic [DW-1:0] q_data[$];
  logic [1:0]    q_size[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_chan_seq #(.AW(AW), .CW(CW), .DW(DW)) u_dma_chan_seq (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_src(cfg_src),
    .cfg_dst(cfg_dst), .cfg_cnt(cfg_cnt), .ch_en(ch_en), .mst_en(mst_en),
    .irq_en(irq_en), .burst_mode(burst_mode), .xfer_size(xfer_size),
    .req_src(req_src), .ext_req(ext_req), .per_req(per_req),
    .nmi_evt(nmi_evt), .addr_err(addr_err), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .bus_hold(bus_hold), .end_flag(end_flag), .nmi_flag(nmi_flag),
    .done_irq(done_irq), .cur_src(cur_src), .cur_dst(cur_dst),
    .cur_cnt(cur_cnt)
  );

  function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
    pat = {a[15:0] ^ 16'h5A5A, ~a[15:0]};
  endfunction

  // Memory model: acknowledges each access one cycle after it appears.
  logic ack_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ack_q <= 1'b0;
    else        ack_q <= mem_req && !ack_q;
  end
  assign mem_ack   = ack_q;
  assign mem_rdata = pat(mem_addr);

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  // Scoreboard monitor: pops one expected write per completed write access.
  always @(negedge clk) begin
    if (rst_n && mem_req) req_seen++;
    if (rst_n && mem_req && mem_we && mem_ack) begin
      wr_seen++;
      first_wr = 1'b1;
      total++;
      if (q_addr.size() == 0) begin
        bad++;
        $display("FAIL R3 unexpected write: got=%0h exp=none", mem_addr);
      end else begin
        logic [AW-1:0] ea;
        logic [DW-1:0] ed;
        logic [1:0]    es;
        ea = q_addr.pop_front();
        ed = q_data.pop_front();
        es = q_size.pop_front();
        if (mem_addr !== ea || mem_wdata !== ed || mem_size !== es) begin
          bad++;
          $display("FAIL R3 write: got=%0h/%0h/%0d exp=%0h/%0h/%0d",
                   mem_addr, mem_wdata, mem_size, ea, ed, es);
        end
      end
    end
    if (run_on && first_wr && !bus_hold && !end_flag) gaps++;
  end

  // Driver: queue the writes a run of n units must produce.
  task automatic expect_units(input logic [AW-1:0] s, input logic [AW-1:0] d,
                              input int n, input logic [1:0] sz);
    int b;
    b = (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
    for (int i = 0; i < n; i++) begin
      q_addr.push_back(d + AW'(i * b));
      q_data.push_back(pat(s + AW'(i * b)));
      q_size.push_back(sz);
    end
  endtask

  task automatic load(input logic [AW-1:0] s, input logic [AW-1:0] d, input int n);
    @(negedge clk);
    cfg_src = s; cfg_dst = d; cfg_cnt = CW'(n); cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  task automatic wait_end(input int lim);
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      if (end_flag) break;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_write;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (mem_req && mem_we && mem_ack) break;
    end
  endtask

  task automatic start_run;
    gaps = 0; first_wr = 1'b0; run_on = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: got=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int w0, r0;
    idle(3);
    // R10 reset state
    check("R10 mem_req in reset", 32'(mem_req), 0);
    rst_n = 1'b1;
    idle(1);
    check("R10 bus_hold", 32'(bus_hold), 0);
    check("R10 flags", {29'd0, end_flag, nmi_flag, done_irq}, 0);

    // Burst, auto, longword, interrupt on
    mst_en = 1; req_src = 2'b00; burst_mode = 1; irq_en = 1; xfer_size = 2'b10;
    load(32'h1000, 32'h2000, 4);
    expect_units(32'h1000, 32'h2000, 4, 2'b10);
    w0 = wr_seen; start_run();
    ch_en = 1;
    wait_end(200);
    run_on = 1'b0;
    check("R6 end flag", 32'(end_flag), 1);
    check("R6 irq with irq_en", 32'(done_irq), 1);
    check("R5 count zero", 32'(cur_cnt), 0);
    check("R4 src step 4", cur_src, 32'h1010);
    check("R3 four writes", 32'(wr_seen - w0), 4);
    check("R9 burst no gap", 32'(gaps), 0);
    r0 = req_seen; idle(20);
    check("R1 no restart after end", 32'(req_seen - r0), 0);
    ch_en = 0;

    // Cycle steal, external request, byte, interrupt off
    req_src = 2'b01; burst_mode = 0; irq_en = 0; xfer_size = 2'b00; ext_req = 1;
    load(32'h3001, 32'h4003, 3);
    expect_units(32'h3001, 32'h4003, 3, 2'b00);
    start_run();
    ch_en = 1;
    wait_end(200);
    run_on = 1'b0;
    check("R9 steal gaps", 32'(gaps), 2);
    check("R6 no irq when disabled", 32'(done_irq), 0);
    check("R6 end flag steal", 32'(end_flag), 1);
    check("R4 byte step", cur_src, 32'h3004);
    ch_en = 0;

    // External request low holds off, word size
    ext_req = 0; xfer_size = 2'b01;
    load(32'h5000, 32'h6000, 2);
    ch_en = 1;
    r0 = req_seen; idle(20);
    check("R2 ext low idle", 32'(req_seen - r0), 0);
    expect_units(32'h5000, 32'h6000, 2, 2'b01);
    ext_req = 1;
    wait_end(200);
    check("R4 word step", cur_dst, 32'h6004);
    check("R5 word count", 32'(cur_cnt), 0);
    ch_en = 0; ext_req = 0;

    // Peripheral strobes, one unit each
    req_src = 2'b10; xfer_size = 2'b10;
    load(32'h7000, 32'h8000, 3);
    ch_en = 1;
    r0 = req_seen; idle(10);
    check("R2 periph no strobe", 32'(req_seen - r0), 0);
    expect_units(32'h7000, 32'h8000, 1, 2'b10);
    per_req = 1; idle(1); per_req = 0;
    idle(20);
    check("R5 count after one strobe", 32'(cur_cnt), 2);
    expect_units(32'h7004, 32'h8004, 1, 2'b10);
    per_req = 1; idle(1); per_req = 0;
    idle(20);
    check("R2 second strobe", 32'(cur_cnt), 1);
    check("R6 not ended", 32'(end_flag), 0);
    ch_en = 0;

    // Enable-term gating
    req_src = 2'b00; mst_en = 0;
    load(32'h9000, 32'hA000, 2);
    ch_en = 1;
    r0 = req_seen; idle(20);
    check("R1 master off", 32'(req_seen - r0), 0);
    mst_en = 1; addr_err = 1;
    r0 = req_seen; idle(20);
    check("R1 address error", 32'(req_seen - r0), 0);
    addr_err = 0; xfer_size = 2'b11;
    r0 = req_seen; idle(20);
    check("R4 reserved size", 32'(req_seen - r0), 0);
    ch_en = 0; xfer_size = 2'b10;
    load(32'h9000, 32'hA000, 0);
    ch_en = 1;
    r0 = req_seen; idle(20);
    check("R5 zero count", 32'(req_seen - r0), 0);
    ch_en = 0;

    // NMI abort in the middle of unit 2
    burst_mode = 1; irq_en = 1;
    load(32'hB000, 32'hC000, 8);
    expect_units(32'hB000, 32'hC000, 2, 2'b10);
    w0 = wr_seen;
    ch_en = 1;
    wait_write();
    idle(2);
    nmi_evt = 1; idle(1); nmi_evt = 0;
    idle(40);
    check("R7 units done", 32'(wr_seen - w0), 2);
    check("R7 nmi flag", 32'(nmi_flag), 1);
    check("R7 count kept", 32'(cur_cnt), 6);
    check("R7 no end no irq", {30'd0, end_flag, done_irq}, 0);
    check("R7 src kept", cur_src, 32'hB008);
    ch_en = 0;

    // Enable cleared mid unit, then resumed
    xfer_size = 2'b01;
    load(32'hD000, 32'hE000, 5);
    check("R7 load clears nmi", 32'(nmi_flag), 0);
    expect_units(32'hD000, 32'hE000, 2, 2'b01);
    w0 = wr_seen;
    ch_en = 1;
    wait_write();
    idle(2);
    ch_en = 0;
    idle(40);
    check("R8 units done", 32'(wr_seen - w0), 2);
    check("R8 count kept", 32'(cur_cnt), 3);
    check("R8 no end", 32'(end_flag), 0);
    expect_units(32'hD004, 32'hE004, 3, 2'b01);
    ch_en = 1;
    wait_end(200);
    check("R8 resumed to end", 32'(cur_cnt), 0);
    check("R8 end flag", 32'(end_flag), 1);
    check("R3 queue drained", 32'(q_addr.size()), 0);
    ch_en = 0;

    idle(2);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule